// File: doc/BRIEF.md
# Parallel DMA Interface Control Unit

This block is the register and control core of a 16-bit parallel interface board with DMA. A host reaches it through a word-addressed register port with a one-cycle registered read path. Through that port the host loads function latches that drive the external device, starts block transfers with a GO command, selects the bus address modifier and interrupt vector, and reads back a status word that combines sticky event flags with the live state of the device inputs.

During a transfer the block holds a request to an external bus-master engine. Each granted cycle advances a 32-bit byte address by two and decrements a word range counter. When the counter runs out, the block raises end of range and returns to ready. A bus error or bus timeout ends the transfer at once. An interrupt line is raised when interrupts are enabled and either end of range or a captured attention edge is pending. It stays up until the host clears the flag with a write-one-to-clear bit in the control word.

Top module: `pdma_ctl`

## Requirements
- R1: After reset every flag, latch, interrupt enable and DMA activity is clear, `irq`, `dma_req` and `dev_go` are low, and a status read at offset 0x00 returns 0x0081 with all device inputs low. Bit 7 is ready (high while no transfer runs) and bit 0 is the fixed variant flag, which is 1.
- R2: The low and high DMA address halves are written at 0x12 and 0x1A and read back at 0x16 and 0x1E. `dma_addr` is {high,low}. A read of 0x12, 0x1A or any unused offset returns 0.
- R3: A control write (offset 0x00) with bit 0 set and bit 12 clear, while idle and with a nonzero range, makes `dev_go` high for exactly one cycle and raises `dma_req`. Ready (status bit 7) then reads 0.
- R4: Each cycle with `dma_req` and `dma_grant` high and no bus error or timeout advances `dma_addr` by 2, carrying from the low half into the high half, and decrements the range counter (offset 0x14, counted in words).
- R5: The grant that takes the range counter from 1 to 0 drops `dma_req` and sets the end-of-range flag (status bit 15). A GO issued while the range counter is 0 sets end of range without raising `dma_req`.
- R6: A low-to-high change of `dev_attn` sets the sticky attention flag (status bit 14), and a level that stays high does not set it again. Status bit 13 shows the sampled attention level, bit 12 is a sticky flag set by `dev_perr`, and bits 11, 10 and 9 show `dev_stat[2]`, `dev_stat[1]` and `dev_stat[0]`.
- R7: A control write with bit 15, 14 or 13 set clears end of range, attention or parity error respectively. If the event that sets a flag occurs in the same cycle as the write that clears it, the flag ends up set.
- R8: `irq` is high one cycle after interrupt enable is set while end of range or attention is pending, and low one cycle after the enable or both of those flags clear.
- R9: A write to the pulse register (offset 0x06) with bit 6 set sets interrupt enable. A write with bit 5 set and bit 6 clear clears it. A write with neither bit changes nothing. A control write also loads interrupt enable from bit 6, and status bit 6 reads it back.
- R10: A bus error (`dma_berr`) or bus timeout (`dma_tmo`) while `dma_req` is high drops `dma_req` at once without advancing the address. It sets status bit 5 or bit 4 respectively. The next GO that starts a transfer clears both.
- R11: A control write with bit 12 set pulses `dev_mclr` for one cycle and clears the sticky flags, the function latches, interrupt enable and DMA activity. All other bits of that write are ignored. The address and range registers keep their values.
- R12: Control bits 3, 2 and 1 load latches that drive `dev_fn[2]`, `dev_fn[1]` and `dev_fn[0]` and read back in status bits 3 to 1. `dev_fn2_aux` follows the bit-2 latch.
- R13: A control write with bit 8 set gives a one-cycle `dma_force` pulse while a transfer is active, and no pulse while idle.
- R14: A write to offset 0x02 drives `dev_dout`, and a read of 0x02 returns `dev_din`. Offset 0x04 holds the address modifier in bits 15:8 (driving `dma_amod`) and the interrupt vector in bits 7:0 (driving `irq_vec`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Register byte offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| dev_dout | output | 16 | Data register towards the device |
| dev_din | input | 16 | Data from the device |
| dev_fn | output | 3 | Function lines 3..1 |
| dev_fn2_aux | output | 1 | Companion line of function 2 |
| dev_go | output | 1 | One-cycle GO strobe |
| dev_mclr | output | 1 | One-cycle master-clear strobe |
| dev_attn | input | 1 | Attention input |
| dev_perr | input | 1 | Parity error input |
| dev_stat | input | 3 | Status inputs A, B, C |
| dma_req | output | 1 | Transfer active, requests bus cycles |
| dma_addr | output | 32 | Current DMA byte address |
| dma_amod | output | 8 | Bus address modifier |
| dma_force | output | 1 | One-cycle forced-cycle request |
| dma_grant | input | 1 | Bus cycle granted this clock |
| dma_berr | input | 1 | Bus error on the current cycle |
| dma_tmo | input | 1 | Bus timeout on the current cycle |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
Setting a sticky flag and clearing it through the control word can fall in the same clock edge. The bench provokes this twice. It aligns a clear-attention write with the edge on which the attention rise is detected, and it drives the final grant of a transfer together with a clear-end-of-range write. In both cases the status read that follows must still show the flag, and `irq` must rise one cycle later. A second clear write must then remove the flag.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int DW    = 16;
  localparam int OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_CSR   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_DATA  = 5'h02;
  localparam logic [OFS_W-1:0] OFS_VEC   = 5'h04;
  localparam logic [OFS_W-1:0] OFS_PULSE = 5'h06;
  localparam logic [OFS_W-1:0] OFS_WALO  = 5'h12;
  localparam logic [OFS_W-1:0] OFS_RANGE = 5'h14;
  localparam logic [OFS_W-1:0] OFS_RALO  = 5'h16;
  localparam logic [OFS_W-1:0] OFS_WAHI  = 5'h1A;
  localparam logic [OFS_W-1:0] OFS_RAHI  = 5'h1E;

  // control word bits
  localparam int C_CLR_EOR = 15;
  localparam int C_CLR_ATF = 14;
  localparam int C_CLR_PER = 13;
  localparam int C_MCLR    = 12;
  localparam int C_FORCE   = 8;
  localparam int C_IEN     = 6;
  localparam int C_GO      = 0;
  // pulse register bits
  localparam int P_SET     = 6;
  localparam int P_CLR     = 5;
endpackage

// File: rtl/pdma_flags.sv
module pdma_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic clr_eor,
  input  logic clr_atf,
  input  logic clr_per,
  input  logic set_eor,
  input  logic attn_in,
  input  logic perr_in,
  input  logic ien_wr,
  input  logic ien_val,
  input  logic ien_set,
  input  logic ien_clr,
  output logic eor,
  output logic atf,
  output logic per,
  output logic attn_lvl,
  output logic ien,
  output logic irq
);
  logic attn_q2;
  logic attn_rise;

  assign attn_lvl  = attn_q2 ? 1'b1 : 1'b0;
  logic attn_q;
  assign attn_rise = attn_q & ~attn_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_q  <= 1'b0;
      attn_q2 <= 1'b0;
    end else begin
      attn_q  <= attn_in;
      attn_q2 <= attn_q;
    end
  end

  // sticky flags: a set event in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      eor <= 1'b0;
      atf <= 1'b0;
      per <= 1'b0;
    end else begin
      if (set_eor)        eor <= 1'b1;
      else if (clr_eor)   eor <= 1'b0;
      if (attn_rise)      atf <= 1'b1;
      else if (clr_atf)   atf <= 1'b0;
      if (perr_in)        per <= 1'b1;
      else if (clr_per)   per <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all)  ien <= 1'b0;
    else if (ien_set)    ien <= 1'b1;
    else if (ien_clr)    ien <= 1'b0;
    else if (ien_wr)     ien <= ien_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) irq <= 1'b0;
    else                irq <= ien & (eor | atf);
  end
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer #(
  parameter int DW    = 16,
  parameter int RNG_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic            go,
  input  logic            force_req,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_rng,
  input  logic [DW-1:0]   wdata,
  input  logic            grant,
  input  logic            berr,
  input  logic            tmo,
  output logic [2*DW-1:0] addr,
  output logic [RNG_W-1:0] rng,
  output logic            active,
  output logic            berr_f,
  output logic            tmo_f,
  output logic            done,
  output logic            force_pulse
);
  localparam int AW = 2 * DW;

  logic fault, step, last, start, zero_go;

  assign fault   = active & (berr | tmo);
  assign step    = active & grant & ~berr & ~tmo;
  assign last    = (rng == RNG_W'(1));
  assign start   = go & ~active & (rng != '0);
  assign zero_go = go & ~active & (rng == '0);
  assign done    = (step & last) | zero_go;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      active <= 1'b0;
      berr_f <= 1'b0;
      tmo_f  <= 1'b0;
    end else if (fault) begin
      active <= 1'b0;
      berr_f <= berr_f | berr;
      tmo_f  <= tmo_f | tmo;
    end else if (step && last) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      berr_f <= 1'b0;
      tmo_f  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      rng  <= '0;
    end else begin
      if (step) begin
        addr <= addr + AW'(2);
        rng  <= rng - RNG_W'(1);
      end
      if (wr_lo)  addr[DW-1:0]  <= wdata;
      if (wr_hi)  addr[AW-1:DW] <= wdata;
      if (wr_rng) rng           <= wdata[RNG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) force_pulse <= 1'b0;
    else                force_pulse <= force_req & active;
  end
endmodule

// File: rtl/pdma_ctl.sv
module pdma_ctl
  import pdma_pkg::*;
#(
  parameter int   RNG_W   = 16,
  parameter logic VARIANT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             host_rvalid,
  output logic [DW-1:0]    dev_dout,
  input  logic [DW-1:0]    dev_din,
  output logic [2:0]       dev_fn,
  output logic             dev_fn2_aux,
  output logic             dev_go,
  output logic             dev_mclr,
  input  logic             dev_attn,
  input  logic             dev_perr,
  input  logic [2:0]       dev_stat,
  output logic             dma_req,
  output logic [2*DW-1:0]  dma_addr,
  output logic [7:0]       dma_amod,
  output logic             dma_force,
  input  logic             dma_grant,
  input  logic             dma_berr,
  input  logic             dma_tmo,
  output logic             irq,
  output logic [7:0]       irq_vec
);
  localparam int AW = 2 * DW;

  logic wr_csr, wr_pulse, mclr, ctl;
  logic eor_w, atf_w, per_w, attl_w, ien_w;
  logic berr_w, tmo_w, done_w;
  logic [RNG_W-1:0] rng_w;
  logic [2:0] stat_q;
  logic [DW-1:0] status_w;
  logic [DW-1:0] rd_mux;

  assign wr_csr   = host_wr && (host_addr == OFS_CSR);
  assign wr_pulse = host_wr && (host_addr == OFS_PULSE);
  assign mclr     = wr_csr & host_wdata[C_MCLR];
  assign ctl      = wr_csr & ~host_wdata[C_MCLR];

  pdma_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (mclr),
    .clr_eor  (ctl & host_wdata[C_CLR_EOR]),
    .clr_atf  (ctl & host_wdata[C_CLR_ATF]),
    .clr_per  (ctl & host_wdata[C_CLR_PER]),
    .set_eor  (done_w),
    .attn_in  (dev_attn),
    .perr_in  (dev_perr),
    .ien_wr   (ctl),
    .ien_val  (host_wdata[C_IEN]),
    .ien_set  (wr_pulse & host_wdata[P_SET]),
    .ien_clr  (wr_pulse & host_wdata[P_CLR]),
    .eor      (eor_w),
    .atf      (atf_w),
    .per      (per_w),
    .attn_lvl (attl_w),
    .ien      (ien_w),
    .irq      (irq)
  );

  pdma_xfer #(.DW(DW), .RNG_W(RNG_W)) u_xfer (
    .clk         (clk),
    .rst         (rst),
    .clr_all     (mclr),
    .go          (ctl & host_wdata[C_GO]),
    .force_req   (ctl & host_wdata[C_FORCE]),
    .wr_lo       (host_wr && (host_addr == OFS_WALO)),
    .wr_hi       (host_wr && (host_addr == OFS_WAHI)),
    .wr_rng      (host_wr && (host_addr == OFS_RANGE)),
    .wdata       (host_wdata),
    .grant       (dma_grant),
    .berr        (dma_berr),
    .tmo         (dma_tmo),
    .addr        (dma_addr),
    .rng         (rng_w),
    .active      (dma_req),
    .berr_f      (berr_w),
    .tmo_f       (tmo_w),
    .done        (done_w),
    .force_pulse (dma_force)
  );

  // function latches, strobes, plain registers
  always_ff @(posedge clk) begin
    if (rst || mclr) dev_fn <= '0;
    else if (ctl)    dev_fn <= host_wdata[3:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_go   <= 1'b0;
      dev_mclr <= 1'b0;
      dev_dout <= '0;
      dma_amod <= '0;
      irq_vec  <= '0;
      stat_q   <= '0;
    end else begin
      dev_go   <= ctl & host_wdata[C_GO];
      dev_mclr <= mclr;
      stat_q   <= dev_stat;
      if (host_wr && host_addr == OFS_DATA) dev_dout <= host_wdata;
      if (host_wr && host_addr == OFS_VEC) begin
        dma_amod <= host_wdata[15:8];
        irq_vec  <= host_wdata[7:0];
      end
    end
  end

  assign dev_fn2_aux = dev_fn[1];

  assign status_w = {eor_w, atf_w, attl_w, per_w, stat_q, 1'b0,
                     ~dma_req, ien_w, berr_w, tmo_w, dev_fn, VARIANT};

  always_comb begin
    unique case (host_addr)
      OFS_CSR:   rd_mux = status_w;
      OFS_DATA:  rd_mux = dev_din;
      OFS_VEC:   rd_mux = {dma_amod, irq_vec};
      OFS_RANGE: rd_mux = DW'(rng_w);
      OFS_RALO:  rd_mux = dma_addr[DW-1:0];
      OFS_RAHI:  rd_mux = dma_addr[AW-1:DW];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pdma_ctl_chk.sv
module pdma_ctl_chk #(
  parameter int AW    = 32,
  parameter int RNG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             dev_go,
  input logic             dev_mclr,
  input logic             dma_req,
  input logic             dma_grant,
  input logic             dma_berr,
  input logic             dma_tmo,
  input logic [AW-1:0]    dma_addr,
  input logic             dma_force,
  input logic             irq,
  input logic [2:0]       dev_fn,
  input logic             ien_w,
  input logic             eor_w,
  input logic             atf_w,
  input logic [RNG_W-1:0] rng_w
);
  // R3: GO strobe lasts one cycle
  a_r3_go_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dev_go |=> !dev_go);

  // R4: granted cycle advances the address by 2
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_grant && !dma_berr && !dma_tmo && !host_wr)
      |=> dma_addr == $past(dma_addr) + AW'(2));

  // R5: last granted word ends the transfer with end of range
  a_r5_last_word: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_grant && !dma_berr && !dma_tmo && !host_wr
     && rng_w == RNG_W'(1)) |=> (!dma_req && eor_w));

  // R8: interrupt only follows an enabled pending flag
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien_w && (eor_w || atf_w)));

  // R10: bus fault stops the transfer at once
  a_r10_fault_stop: assert property (@(posedge clk) disable iff (rst)
    (dma_req && (dma_berr || dma_tmo)) |=> !dma_req);

  // R11: master clear leaves everything idle
  a_r11_mclr_idle: assert property (@(posedge clk) disable iff (rst)
    dev_mclr |-> (!dma_req && !irq && dev_fn == 3'b000 && !ien_w));

  // R13: forced cycle only while a transfer was active
  a_r13_force_active: assert property (@(posedge clk) disable iff (rst)
    dma_force |-> $past(dma_req));
endmodule

bind pdma_ctl pdma_ctl_chk #(.AW(2*pdma_pkg::DW), .RNG_W(RNG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .dev_go    (dev_go),
  .dev_mclr  (dev_mclr),
  .dma_req   (dma_req),
  .dma_grant (dma_grant),
  .dma_berr  (dma_berr),
  .dma_tmo   (dma_tmo),
  .dma_addr  (dma_addr),
  .dma_force (dma_force),
  .irq       (irq),
  .dev_fn    (dev_fn),
  .ien_w     (ien_w),
  .eor_w     (eor_w),
  .atf_w     (atf_w),
  .rng_w     (rng_w)
);

// File: tb/pdma_ctl_tb.sv
module pdma_ctl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic        host_rvalid;
  logic [15:0] dev_dout, dev_din = '0;
  logic [2:0]  dev_fn, dev_stat = '0;
  logic        dev_fn2_aux, dev_go, dev_mclr;
  logic        dev_attn = 1'b0, dev_perr = 1'b0;
  logic        dma_req, dma_force, irq;
  logic [31:0] dma_addr;
  logic [7:0]  dma_amod, irq_vec;
  logic        dma_grant = 1'b0, dma_berr = 1'b0, dma_tmo = 1'b0;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pdma_ctl u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dev_dout(dev_dout), .dev_din(dev_din),
    .dev_fn(dev_fn), .dev_fn2_aux(dev_fn2_aux), .dev_go(dev_go),
    .dev_mclr(dev_mclr), .dev_attn(dev_attn), .dev_perr(dev_perr),
    .dev_stat(dev_stat), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_amod(dma_amod), .dma_force(dma_force), .dma_grant(dma_grant),
    .dma_berr(dma_berr), .dma_tmo(dma_tmo), .irq(irq), .irq_vec(irq_vec)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // scoreboard monitor: compare read data as it comes out
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read", 32'(host_rdata), 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), 32'(host_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grant(input int n);
    @(negedge clk); dma_grant = 1'b1;
    repeat (n) @(negedge clk);
    dma_grant = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0); chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 dev_go", 32'(dev_go), 0);
    rd(5'h00, 16'h0081, "R1 status after reset");
    // R2 address offsets
    wr(5'h12, 16'hFFFC); wr(5'h1A, 16'h0001);
    rd(5'h16, 16'hFFFC, "R2 low read"); rd(5'h1E, 16'h0001, "R2 high read");
    rd(5'h12, 16'h0000, "R2 write-only low"); rd(5'h08, 16'h0000, "R2 unused");
    chk("R2 dma_addr", dma_addr, 32'h0001_FFFC);
    // R14 data and vector
    wr(5'h02, 16'hA55A); chk("R14 dev_dout", 32'(dev_dout), 32'hA55A);
    dev_din = 16'h1234; rd(5'h02, 16'h1234, "R14 data read");
    wr(5'h04, 16'h3D9C); rd(5'h04, 16'h3D9C, "R14 vector word");
    chk("R14 amod", 32'(dma_amod), 32'h3D); chk("R14 vec", 32'(irq_vec), 32'h9C);
    // R12 function latches
    wr(5'h00, 16'h000E);
    chk("R12 dev_fn", 32'(dev_fn), 3'b111); chk("R12 aux", 32'(dev_fn2_aux), 1);
    rd(5'h00, 16'h008F, "R12 readback");
    wr(5'h00, 16'h0002);
    chk("R12 dev_fn one", 32'(dev_fn), 3'b001); chk("R12 aux low", 32'(dev_fn2_aux), 0);
    // R3 R4 R5 transfer of three words
    wr(5'h14, 16'h0003);
    wr(5'h00, 16'h0001);
    chk("R3 go high", 32'(dev_go), 1); chk("R3 req", 32'(dma_req), 1);
    idle(1); chk("R3 go one cycle", 32'(dev_go), 0);
    rd(5'h00, 16'h0001, "R3 not ready");
    grant(1); chk("R4 addr step", dma_addr, 32'h0001_FFFE);
    grant(1); chk("R4 carry", dma_addr, 32'h0002_0000);
    rd(5'h14, 16'h0001, "R4 range");
    grant(1); chk("R5 req drop", 32'(dma_req), 0);
    chk("R4 addr final", dma_addr, 32'h0002_0002);
    rd(5'h00, 16'h8081, "R5 end of range");
    idle(1); chk("R8 irq masked", 32'(irq), 0);
    // R9 R8 pulse register and interrupt
    wr(5'h06, 16'h0040); idle(1); chk("R8 irq on", 32'(irq), 1);
    rd(5'h00, 16'h80C1, "R9 ien set");
    wr(5'h06, 16'h009F); idle(1); chk("R9 other bits no effect", 32'(irq), 1);
    rd(5'h00, 16'h80C1, "R9 ien kept");
    wr(5'h06, 16'h0020); idle(1); chk("R9 ien clear irq", 32'(irq), 0);
    wr(5'h06, 16'h0040); idle(1); chk("R8 irq again", 32'(irq), 1);
    wr(5'h00, 16'h8040); idle(1); chk("R7 irq after clear", 32'(irq), 0);
    rd(5'h00, 16'h00C1, "R7 eor cleared");
    // R6 R7 attention edge colliding with its clear
    @(negedge clk); dev_attn = 1'b1;
    wr(5'h00, 16'h4040);
    idle(1); chk("R7 set wins irq", 32'(irq), 1);
    rd(5'h00, 16'h60C1, "R7 attention set wins");
    wr(5'h00, 16'h4040); idle(1); chk("R8 irq drop", 32'(irq), 0);
    idle(3); rd(5'h00, 16'h20C1, "R6 level held no new edge");
    @(negedge clk); dev_attn = 1'b0;
    @(negedge clk); dev_perr = 1'b1;
    @(negedge clk); dev_perr = 1'b0;
    idle(1); rd(5'h00, 16'h10C1, "R6 parity sticky");
    wr(5'h00, 16'h2040); rd(5'h00, 16'h00C1, "R7 parity cleared");
    dev_stat = 3'b101; idle(2); rd(5'h00, 16'h0AC1, "R6 status inputs");
    dev_stat = 3'b000;
    // R10 bus error and timeout
    wr(5'h14, 16'h0005); wr(5'h00, 16'h0041);
    grant(1);
    @(negedge clk); dma_grant = 1'b1; dma_berr = 1'b1;
    @(negedge clk); dma_grant = 1'b0; dma_berr = 1'b0;
    chk("R10 berr stop", 32'(dma_req), 0);
    chk("R10 addr held", dma_addr, 32'h0002_0004);
    rd(5'h00, 16'h00E1, "R10 berr flag");
    rd(5'h14, 16'h0004, "R10 range held");
    wr(5'h00, 16'h0041); chk("R10 restart", 32'(dma_req), 1);
    @(negedge clk); dma_tmo = 1'b1;
    @(negedge clk); dma_tmo = 1'b0;
    chk("R10 tmo stop", 32'(dma_req), 0);
    rd(5'h00, 16'h00D1, "R10 timeout flag, berr cleared by GO");
    // R13 forced cycle
    wr(5'h00, 16'h0140); chk("R13 no force idle", 32'(dma_force), 0);
    wr(5'h00, 16'h0041);
    wr(5'h00, 16'h0140); chk("R13 force active", 32'(dma_force), 1);
    idle(1); chk("R13 force one cycle", 32'(dma_force), 0);
    // R7 last grant colliding with clear of end of range
    grant(3);
    @(negedge clk); dma_grant = 1'b1; host_addr = 5'h00; host_wdata = 16'h8040; host_wr = 1'b1;
    @(negedge clk); dma_grant = 1'b0; host_wr = 1'b0;
    chk("R5 last word drop", 32'(dma_req), 0);
    chk("R4 addr after run", dma_addr, 32'h0002_000C);
    idle(1); chk("R7 eor set wins irq", 32'(irq), 1);
    rd(5'h00, 16'h80C1, "R7 eor set wins");
    wr(5'h00, 16'h8040); rd(5'h00, 16'h00C1, "R7 eor cleared again");
    // R11 master clear
    wr(5'h14, 16'h0010);
    @(negedge clk); dev_attn = 1'b1; idle(3); dev_attn = 1'b0;
    wr(5'h00, 16'h004F); chk("R11 active before", 32'(dma_req), 1);
    rd(5'h00, 16'h404F, "R11 state before clear");
    wr(5'h00, 16'h104F);
    chk("R11 mclr pulse", 32'(dev_mclr), 1); chk("R11 req", 32'(dma_req), 0);
    chk("R11 fn", 32'(dev_fn), 0); chk("R11 irq", 32'(irq), 0);
    chk("R11 no go", 32'(dev_go), 0);
    idle(1); chk("R11 mclr one cycle", 32'(dev_mclr), 0);
    rd(5'h00, 16'h0081, "R11 status cleared");
    rd(5'h14, 16'h0010, "R11 range kept");
    // R5 GO with zero range
    wr(5'h14, 16'h0000); wr(5'h00, 16'h0001);
    chk("R5 zero go no req", 32'(dma_req), 0);
    rd(5'h00, 16'h8081, "R5 zero range end");
    idle(3);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule